// File: doc/BRIEF.md
# Field Memory Playback Output Controller

This block moves pixels from an internal first-word-fall-through FIFO onto a video output port that feeds an external field memory. The memory is written continuously as pixels become available rather than on a fixed raster. The pixel clock is therefore variable in effect: it is set by how often the FIFO holds data. Every transferred pixel carries a one-cycle write-enable strobe. The output rate never exceeds one pixel per two cycles of the line-locked clock.

The vertical sync input is the timing reference. After reset the block stays idle until it sees the first rising edge of vertical sync. Each rising edge produces a one-cycle field-reset strobe that returns the external memory to its start address. The first pixel of the new field follows that strobe. When the FIFO is empty, output pauses and resumes in order once data arrives, so no pixel is dropped or repeated. A per-field pixel count is brought out so that the data written in each field can be checked.

Top module: `fm_playback_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `fifo_pop`, `pix_we` and `fld_rst` are 0 and `pix_data` and `pix_count` are all zeros.
- R2: After reset and before the first rising edge of `vsync` is sampled, `fifo_pop` and `pix_we` stay 0 even when the FIFO holds data.
- R3: A clock edge that samples `vsync` high, when the previous edge sampled it low, makes `fld_rst` high for exactly the next cycle. If `vsync` is held high, no further pulse follows.
- R4: `fifo_pop` is 0 in the cycle in which a rising edge of `vsync` is being sampled. So `pix_we` is 0 while `fld_rst` is high, and the first pixel of a field follows the field reset.
- R5: `fifo_pop` is high only in a cycle where `fifo_empty` is low.
- R6: One cycle after `fifo_pop`, `pix_we` is high and `pix_data` equals the `fifo_data` present at the pop. Without a pop, `pix_we` is 0 in the next cycle.
- R7: `fifo_pop` is never high in two consecutive cycles (PACE = 2 by default), so at most one pixel is written per two clock cycles.
- R8: While the block is streaming, the FIFO is non-empty and no `vsync` edge occurs, it pops as soon as pacing allows: exactly 20 pixels in any 40 consecutive cycles.
- R9: In a cycle where `pix_we` is 0, `pix_data` keeps the value it had in the previous cycle.
- R10: `pix_count` is 0 in the cycle in which `fld_rst` is high, and it is one greater than before in every cycle in which `pix_we` is high.
- R11: Every pixel that is popped is written exactly once, in FIFO order, across empty gaps and field boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync | input | 1 | Vertical sync reference, rising edge starts a field |
| fifo_empty | input | 1 | FIFO holds no pixel when high |
| fifo_data | input | PIX_W | Head pixel of the FIFO (valid while not empty) |
| fifo_pop | output | 1 | Consumes the head pixel at this clock edge |
| pix_data | output | PIX_W | Pixel presented to the field memory |
| pix_we | output | 1 | Write strobe for `pix_data` |
| fld_rst | output | 1 | One-cycle address reset for the field memory |
| pix_count | output | CNT_W | Pixels written since the last field reset |

## Verification
The interesting collision is a `vsync` rising edge that lands in the same cycle as a pop that would otherwise be taken, with data waiting and the pacing window open. The bench creates it by holding the FIFO artificially empty for a few cycles, so that the pacer has run out, and then releasing the data in the same cycle as the edge. It then checks that no pop happens in that cycle, that the field reset appears alone with a zero count, and that the waiting pixel follows one cycle later as pixel one of the new field. A second overlap, a write still in flight when the next edge arrives, is covered by random empty gaps around field starts and judged by the scoreboard order and count.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic {
        FLD_WAIT = 1'b0,
        FLD_RUN  = 1'b1
    } fld_state_e;

    typedef struct packed {
        logic rise;
        logic armed;
        logic pace_ok;
        logic avail;
    } pop_ctl_t;

    function automatic logic edge_up(input logic now, input logic prev);
        return now & ~prev;
    endfunction

    function automatic logic pop_grant(input pop_ctl_t c);
        return c.avail & c.armed & c.pace_ok & ~c.rise;
    endfunction

endpackage

// File: rtl/fm_field_sync.sv
module fm_field_sync
    import fm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vsync,
    output logic rise,
    output logic armed,
    output logic fld_rst
);
    logic       vs_prev;
    fld_state_e state;

    assign rise  = edge_up(vsync, vs_prev);
    assign armed = (state == FLD_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_prev <= 1'b0;
            state   <= FLD_WAIT;
            fld_rst <= 1'b0;
        end else begin
            vs_prev <= vsync;
            fld_rst <= rise;
            if (rise) begin
                state <= FLD_RUN;
            end
        end
    end
endmodule

// File: rtl/fm_pacer.sv
module fm_pacer #(
    parameter int PACE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pop,
    output logic pace_ok
);
    generate
        if (PACE <= 1) begin : g_free
            assign pace_ok = 1'b1;
        end else begin : g_cool
            localparam int CD_W = $clog2(PACE);
            localparam logic [CD_W-1:0] CD_LOAD = CD_W'(PACE - 1);
            logic [CD_W-1:0] cd;

            assign pace_ok = (cd == '0);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cd <= '0;
                end else if (pop) begin
                    cd <= CD_LOAD;
                end else if (cd != '0) begin
                    cd <= cd - 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/fm_out_stage.sv
module fm_out_stage #(
    parameter int PIX_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pop,
    input  logic             clr,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] pix_data,
    output logic             pix_we,
    output logic [CNT_W-1:0] pix_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_data  <= '0;
            pix_we    <= 1'b0;
            pix_count <= '0;
        end else begin
            pix_we <= pop;
            if (pop) begin
                pix_data <= din;
            end
            if (clr) begin
                pix_count <= '0;
            end else if (pop) begin
                pix_count <= pix_count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/fm_playback_ctrl.sv
module fm_playback_ctrl
    import fm_pkg::*;
#(
    parameter int PIX_W = 16,
    parameter int CNT_W = 16,
    parameter int PACE  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vsync,
    input  logic             fifo_empty,
    input  logic [PIX_W-1:0] fifo_data,
    output logic             fifo_pop,
    output logic [PIX_W-1:0] pix_data,
    output logic             pix_we,
    output logic             fld_rst,
    output logic [CNT_W-1:0] pix_count
);
    pop_ctl_t ctl;
    logic     rise;
    logic     armed;
    logic     pace_ok;

    fm_field_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .vsync   (vsync),
        .rise    (rise),
        .armed   (armed),
        .fld_rst (fld_rst)
    );

    fm_pacer #(.PACE(PACE)) u_pace (
        .clk     (clk),
        .rst     (rst),
        .pop     (fifo_pop),
        .pace_ok (pace_ok)
    );

    always_comb begin
        ctl.rise    = rise;
        ctl.armed   = armed;
        ctl.pace_ok = pace_ok;
        ctl.avail   = ~fifo_empty;
    end

    assign fifo_pop = pop_grant(ctl);

    fm_out_stage #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .pop       (fifo_pop),
        .clr       (rise),
        .din       (fifo_data),
        .pix_data  (pix_data),
        .pix_we    (pix_we),
        .pix_count (pix_count)
    );
endmodule

// File: rtl/fm_playback_chk.sv
module fm_playback_chk #(
    parameter int PIX_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             vsync,
    input logic             fifo_empty,
    input logic [PIX_W-1:0] fifo_data,
    input logic             fifo_pop,
    input logic [PIX_W-1:0] pix_data,
    input logic             pix_we,
    input logic             fld_rst,
    input logic [CNT_W-1:0] pix_count
);
    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);

    assert_fld_single_R3: assert property (@(posedge clk) disable iff (rst)
        fld_rst |=> !fld_rst);

    assert_fld_from_vsync_R3: assert property (@(posedge clk) disable iff (rst)
        fld_rst |-> $past(vsync));

    assert_no_we_at_fld_R4: assert property (@(posedge clk) disable iff (rst)
        fld_rst |-> !pix_we);

    assert_pop_to_we_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (pix_we && pix_data == $past(fifo_data)));

    assert_idle_no_we_R6: assert property (@(posedge clk) disable iff (rst)
        !fifo_pop |=> !pix_we);

    assert_pace_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    assert_hold_data_R9: assert property (@(posedge clk) disable iff (rst)
        !fifo_pop |=> $stable(pix_data));

    assert_count_clear_R10: assert property (@(posedge clk) disable iff (rst)
        fld_rst |-> (pix_count == '0));

    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> (pix_count == $past(pix_count) + CNT_W'(1)));
endmodule

bind fm_playback_ctrl fm_playback_chk #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .vsync      (vsync),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_pop   (fifo_pop),
    .pix_data   (pix_data),
    .pix_we     (pix_we),
    .fld_rst    (fld_rst),
    .pix_count  (pix_count)
);

// File: tb/test_fm_playback_ctrl.sv
module test_fm_playback_ctrl;
    localparam int PIX_W = 16;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             vsync = 1'b0;
    logic             fifo_empty = 1'b1;
    logic [PIX_W-1:0] fifo_data = '0;
    logic             fifo_pop;
    logic [PIX_W-1:0] pix_data;
    logic             pix_we;
    logic             fld_rst;
    logic [CNT_W-1:0] pix_count;

    int n_chk = 0;
    int n_bad = 0;

    logic [PIX_W-1:0] src_q[$];
    logic [PIX_W-1:0] exp_q[$];
    logic pop_seen  = 1'b0;
    logic last_pop  = 1'b0;
    logic rise_seen = 1'b0;
    logic exp_fld   = 1'b0;
    logic vs_cur    = 1'b0;
    logic armed_m   = 1'b0;
    logic mon_en    = 1'b0;
    logic done      = 1'b0;
    int   exp_cnt   = 0;
    logic [PIX_W-1:0] last_data = '0;
    logic [PIX_W-1:0] next_val  = 16'h0100;
    logic [7:0] lfsr = 8'hA5;
    int   pops_win  = 0;

    always #4 clk = ~clk;

    fm_playback_ctrl #(.PIX_W(PIX_W), .CNT_W(CNT_W)) i_fm_playback_ctrl (
        .clk(clk), .rst(rst), .vsync(vsync), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .pix_data(pix_data),
        .pix_we(pix_we), .fld_rst(fld_rst), .pix_count(pix_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic load(input int n);
        for (int i = 0; i < n; i++) begin
            src_q.push_back(next_val);
            next_val = next_val + 16'h0011;
        end
    endtask

    // driver: one clock cycle of stimulus
    task automatic cycle(input logic vs, input logic gate);
        @(negedge clk);
        if (pop_seen) begin
            exp_q.push_back(src_q[0]);
            void'(src_q.pop_front());
        end
        exp_fld   = rise_seen;
        rise_seen = vs && !vs_cur;
        vs_cur    = vs;
        vsync     = vs;
        fifo_empty = gate || (src_q.size() == 0);
        fifo_data  = (src_q.size() != 0) ? src_q[0] : '0;
        #1;
        last_pop = pop_seen;
        pop_seen = fifo_pop;
        if (fifo_pop) pops_win++;
        if (fifo_pop && fifo_empty) check(0, "R5 pop while empty", 1, 0);
        if (rise_seen) check(!fifo_pop, "R4 pop in vsync edge cycle", fifo_pop, 0);
        if (!armed_m) check(!fifo_pop, "R2 pop before first field", fifo_pop, 0);
        if (last_pop && fifo_pop) check(0, "R7 back-to-back pops", 1, 0);
        if (rise_seen) armed_m = 1'b1;
    endtask

    // monitor: compares outputs against the scoreboard
    always @(negedge clk) begin
        #2;
        if (mon_en) begin
            check(fld_rst == exp_fld, "R3 field reset pulse", fld_rst, exp_fld);
            if (fld_rst) begin
                exp_cnt = 0;
                check(!pix_we, "R4 write during field reset", pix_we, 0);
                check(pix_count == 0, "R10 count cleared", pix_count, 0);
            end
            if (pix_we) begin
                exp_cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R11 unexpected write", pix_data, 0);
                end else begin
                    check(pix_data == exp_q[0], "R6 R11 pixel value", pix_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                check(pix_count == CNT_W'(exp_cnt), "R10 count step", pix_count, exp_cnt);
                last_data = pix_data;
            end else begin
                check(pix_data == last_data, "R9 data held", pix_data, last_data);
            end
        end
    end

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        #2;
        check(!fifo_pop && !pix_we && !fld_rst, "R1 reset controls", {fifo_pop, pix_we, fld_rst}, 0);
        check(pix_data == 0 && pix_count == 0, "R1 reset data", pix_data, 0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(!pix_we && !fld_rst && pix_count == 0, "R1 after reset", pix_count, 0);
        mon_en = 1'b1;

        // R2: data waiting, no vsync edge yet
        load(8);
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0);
        check(src_q.size() == 8, "R2 nothing consumed before field", src_q.size(), 8);

        // R3 R4 R10: first field, vsync held high several cycles
        for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0);
        for (int i = 0; i < 14; i++) cycle(1'b0, 1'b0);

        // R5 R11: random empty gaps with a few field starts
        load(40);
        for (int i = 0; i < 160; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cycle((i % 50) >= 45, lfsr[0] & lfsr[1]);
        end

        // collision: data released in the vsync edge cycle (R4)
        load(4);
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b0);
        check(pop_seen == 1'b0, "R4 pop deferred at edge", pop_seen, 0);
        cycle(1'b1, 1'b0);
        check(pop_seen == 1'b1, "R8 pop right after edge", pop_seen, 1);
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0);

        // R7 R8: throughput with a full FIFO
        load(60);
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0);
        pops_win = 0;
        for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0);
        check(pops_win == 20, "R7 R8 rate over 40 cycles", pops_win, 20);

        // drain and confirm nothing lost (R11)
        for (int i = 0; i < 200; i++) cycle(1'b0, 1'b0);
        check(src_q.size() == 0, "R11 source drained", src_q.size(), 0);
        check(exp_q.size() == 0, "R11 all pixels written", exp_q.size(), 0);

        done = 1'b1;
        summary();
    end
endmodule